// File: doc/BRIEF.md
# Branch Destination Trace Queue

This block is a debug history of taken branches. Each time the core makes its first instruction fetch after a branch, it pulses a capture strobe and supplies the 28-bit fetch address. The block pushes that address, with a valid flag set, into the newest of eight entries. Every entry then moves one position older, and the oldest entry is discarded. The queue shifts on every branch and never stalls, so it always holds the last eight destinations.

A debug agent reads the history through a simple read port. `rd_idx` selects an entry, where 0 is the newest. `rd_data` shows a 32-bit word for that entry at all times. The valid flag is in bit 31, bits 30 to 28 are zero, and the stored address is in bits 27 to 0. Pulsing `rd_strobe` marks the selected entry as consumed, which clears its flag at the next clock edge. A read does not shift the queue.

The reset clears the flags only. The address bits keep their contents through reset.

Top module: `brtrace_queue`

## Requirements
- R1: A capture strobe moves every entry to the next older position at the clock edge. Entry 0 takes the new address, and the old entry 7 is discarded.
- R2: From the cycle after a capture, entry 0 reads back with bit 31 = 1 and with bits 27:0 equal to the captured address.
- R3: Bits 30:28 of `rd_data` always read 0.
- R4: A read strobe without a capture clears, at the clock edge, the flag of the entry selected by `rd_idx` (0 = newest, 7 = oldest). No other flag changes, no address changes and nothing shifts.
- R5: When a read and a capture occur in the same cycle:
  - the word returned in that cycle is the selected pre-capture entry with its flag as it was;
  - after the edge, that entry sits at `rd_idx`+1 with flag 0, and entry 0 holds the new address with flag 1;
  - when `rd_idx` is 7, the selected entry is discarded.
- R6: `rst_n` low at a clock edge clears all eight flags and overrides both strobes. Every address field keeps its prior value.
- R7: `rd_data` follows `rd_idx` within the same cycle. With no strobe and no reset, all entries hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, acting on the valid flags only |
| cap_strobe | input | 1 | One-cycle pulse on the first fetch after a branch |
| cap_addr | input | 28 | Fetch address to capture |
| rd_strobe | input | 1 | Read pulse; consumes the selected entry's flag |
| rd_idx | input | 3 | Entry to read, 0 = newest |
| rd_data | output | 32 | {flag, 3'b000, address} of the selected entry |

## Verification
`rd_data` is combinational from the stored entries and `rd_idx`. The word for a given select is therefore due in the same cycle: the bench drives inputs at the falling edge and compares 1 ns later, before the rising edge. Captures, flag clears and resets take effect at the next rising edge, so their results are checked against the bench model at the following falling-edge sample. Address bits of entries never written are unknown, so only the flag and reserved bits are compared for them.

// File: rtl/brq_pkg.sv
// Package: brq_pkg
// Purpose: shared default sizes for the branch destination trace queue.
// Assumes: the read word is wide enough to hold the flag and the address.
package brq_pkg;
    localparam int BRQ_DEPTH  = 8;
    localparam int BRQ_ADDR_W = 28;
    localparam int BRQ_WORD_W = 32;
endpackage

// File: rtl/brq_slot.sv
// Module: brq_slot
// Purpose: one queue entry, made of a valid flag with reset and an address
//          register without reset.
// Assumes: load has priority over clr; reset touches only the flag.
module brq_slot #(
    parameter int ADDR_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clr,
    input  logic              in_v,
    input  logic [ADDR_W-1:0] in_a,
    output logic              v,
    output logic [ADDR_W-1:0] a
);
    // Flag update: reset clears the flag, a shift loads it, a read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)    v <= 1'b0;
        else if (load) v <= in_v;
        else if (clr)  v <= 1'b0;
    end

    // Address update: only a shift loads it, and it keeps its value through reset.
    always_ff @(posedge clk) begin
        if (rst_n && load) a <= in_a;
    end
endmodule

// File: rtl/brq_ctrl.sv
// Module: brq_ctrl
// Purpose: turns the strobes and the read select into per-entry controls.
// Assumes: rd_idx < DEPTH; a capture overrides an in-place flag clear.
module brq_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             cap_strobe,
    input  logic             rd_strobe,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             shift,
    output logic [DEPTH-1:0] hit,
    output logic [DEPTH-1:0] clr
);
    // Decode: one-hot hit of the entry being read, and in-place clears when there is no shift.
    always_comb begin
        shift = cap_strobe;
        hit   = '0;
        if (rd_strobe) hit[rd_idx] = 1'b1;
        clr   = cap_strobe ? '0 : hit;
    end
endmodule

// File: rtl/brq_rdfmt.sv
// Module: brq_rdfmt
// Purpose: selects one entry and packs it into the read word.
// Assumes: WORD_W > ADDR_W, with the flag in the top bit and zero fill between.
module brq_rdfmt #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 28,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             v,
    input  logic [DEPTH-1:0][ADDR_W-1:0] a,
    input  logic [IDX_W-1:0]             idx,
    output logic [WORD_W-1:0]            word
);
    // Pack: the flag goes to the MSB, the address to the low bits, the rest is zero.
    always_comb begin
        word               = '0;
        word[WORD_W-1]     = v[idx];
        word[ADDR_W-1:0]   = a[idx];
    end
endmodule

// File: rtl/brtrace_queue.sv
// Module: brtrace_queue
// Purpose: eight-entry branch destination history that shifts on every
//          capture; reading an entry consumes its valid flag.
// Assumes: strobes are synchronous to clk; rd_idx selects an entry, 0 = newest.
module brtrace_queue #(
    parameter int DEPTH  = brq_pkg::BRQ_DEPTH,
    parameter int ADDR_W = brq_pkg::BRQ_ADDR_W,
    parameter int WORD_W = brq_pkg::BRQ_WORD_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_strobe,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic              rd_strobe,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic                         shift;
    logic [DEPTH-1:0]             hit;
    logic [DEPTH-1:0]             clr;
    logic [DEPTH-1:0]             slot_v;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_a;
    logic [DEPTH-1:0]             in_v;
    logic [DEPTH-1:0][ADDR_W-1:0] in_a;

    brq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .cap_strobe (cap_strobe),
        .rd_strobe  (rd_strobe),
        .rd_idx     (rd_idx),
        .shift      (shift),
        .hit        (hit),
        .clr        (clr)
    );

    // Shift sources: entry 0 takes the capture; each older entry takes its neighbour, with the flag dropped if that neighbour is being read.
    always_comb begin
        in_v[0] = 1'b1;
        in_a[0] = cap_addr;
        for (int i = 1; i < DEPTH; i++) begin
            in_v[i] = slot_v[i-1] & ~hit[i-1];
            in_a[i] = slot_a[i-1];
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        brq_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (shift),
            .clr   (clr[g]),
            .in_v  (in_v[g]),
            .in_a  (in_a[g]),
            .v     (slot_v[g]),
            .a     (slot_a[g])
        );
    end

    brq_rdfmt #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_rdfmt (
        .v    (slot_v),
        .a    (slot_a),
        .idx  (rd_idx),
        .word (rd_data)
    );
endmodule

// File: rtl/brq_checker.sv
// Module: brq_checker
// Purpose: temporal checks on the trace queue, attached by bind.
// Assumes: DEPTH >= 2.
module brq_checker #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 28,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cap_strobe,
    input logic [ADDR_W-1:0]            cap_addr,
    input logic                         rd_strobe,
    input logic [IDX_W-1:0]             rd_idx,
    input logic [WORD_W-1:0]            rd_data,
    input logic [DEPTH-1:0]             slot_v,
    input logic [DEPTH-1:0][ADDR_W-1:0] slot_a
);
    logic [DEPTH-1:0] sel;

    // Select mask: one-hot mask of the entry that rd_idx names.
    always_comb sel = DEPTH'(1) << rd_idx;

    assert_shift_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_strobe && !rd_strobe) |=> slot_v[DEPTH-1:1] == $past(slot_v[DEPTH-2:0]));

    assert_capture_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |=> (slot_v[0] && slot_a[0] == $past(cap_addr)));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[WORD_W-2:ADDR_W] == '0);

    assert_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !cap_strobe) |=> ((slot_v & $past(sel)) == '0));

    assert_same_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && cap_strobe) |=> (((slot_v & ($past(sel) << 1)) == '0) && slot_v[0]));

    assert_reset_flags_R6: assert property (@(posedge clk)
        !rst_n |=> slot_v == '0);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_strobe && !rd_strobe) |=> $stable(slot_v));
endmodule

bind brtrace_queue brq_checker #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
) u_brq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_strobe (cap_strobe),
    .cap_addr   (cap_addr),
    .rd_strobe  (rd_strobe),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .slot_v     (slot_v),
    .slot_a     (slot_a)
);

// File: tb/sim_brtrace_queue.sv
module sim_brtrace_queue;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 28;
    localparam int WORD_W = 32;
    localparam int MAX_CYC = 200000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cap_strobe = 1'b0;
    logic [ADDR_W-1:0] cap_addr = '0;
    logic              rd_strobe = 1'b0;
    logic [2:0]        rd_idx = '0;
    logic [WORD_W-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit              mv [DEPTH];
    bit              mk [DEPTH];
    bit [ADDR_W-1:0] ma [DEPTH];

    brtrace_queue u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_strobe (cap_strobe),
        .cap_addr   (cap_addr),
        .rd_strobe  (rd_strobe),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data)
    );

    always #10 clk = ~clk;

    function automatic logic [WORD_W-1:0] exp_word(int idx);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1] = mv[idx];
        w[ADDR_W-1:0] = ma[idx];
        return w;
    endfunction

    task automatic check(string tag);
        logic [WORD_W-1:0] e;
        bit ok;
        e = exp_word(int'(rd_idx));
        n_chk++;
        ok = (rd_data[WORD_W-1:ADDR_W] === e[WORD_W-1:ADDR_W]);
        if (mk[rd_idx]) ok = ok && (rd_data[ADDR_W-1:0] === e[ADDR_W-1:0]);
        if (!ok) begin
            n_bad++;
            $display("FAIL %s idx=%0d got=%h exp=%h", tag, rd_idx, rd_data, e);
        end
    endtask

    task automatic model_edge(bit r, bit c, bit [ADDR_W-1:0] ad, bit rd, int idx);
        if (!r) begin
            for (int i = 0; i < DEPTH; i++) mv[i] = 1'b0;
        end else if (c) begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                mv[i] = mv[i-1] && !(rd && idx == i - 1);
                ma[i] = ma[i-1];
                mk[i] = mk[i-1];
            end
            mv[0] = 1'b1; ma[0] = ad; mk[0] = 1'b1;
        end else if (rd) begin
            mv[idx] = 1'b0;
        end
    endtask

    task automatic step(bit r, bit c, bit [ADDR_W-1:0] ad, bit rd, int idx, string tag);
        @(negedge clk);
        rst_n = r; cap_strobe = c; cap_addr = ad; rd_strobe = rd; rd_idx = 3'(idx);
        #1;
        check(tag);
        model_edge(r, c, ad, rd, idx);
    endtask

    // Peek: look at an entry without any strobe.
    task automatic peek(int idx, string tag);
        step(1'b1, 1'b0, '0, 1'b0, idx, tag);
    endtask

    initial begin
        #(20 * MAX_CYC);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; mk[i] = 0; ma[i] = '0; end
        // R6 reset state: every flag reads 0
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b0, '0, 1'b0, i, "R6_reset");
        // R2 capture then view the head; R3 checked on every word
        step(1'b1, 1'b1, 28'h0ABCDEF, 1'b0, 0, "R2_cap");
        peek(0, "R2_head");
        peek(0, "R3_reserved");
        // R1 eight more captures push the first one out
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b1, 28'h1000000 + 28'(i * 17), 1'b0, 0, "R1_fill");
        for (int i = 0; i < DEPTH; i++) peek(i, "R1_order");
        // R4 read entry 3: only its flag drops
        step(1'b1, 1'b0, '0, 1'b1, 3, "R4_read");
        peek(3, "R4_cleared");
        peek(4, "R4_neighbour");
        peek(2, "R4_neighbour");
        // R5 read entry 2 while capturing
        step(1'b1, 1'b1, 28'hFEED123, 1'b1, 2, "R5_same");
        peek(3, "R5_moved");
        peek(0, "R5_newhead");
        step(1'b1, 1'b1, 28'h0000777, 1'b1, 7, "R5_oldest");
        for (int i = 0; i < DEPTH; i++) peek(i, "R5_after");
        // R6 reset keeps the address fields
        step(1'b0, 1'b1, 28'h5555555, 1'b1, 0, "R6_override");
        for (int i = 0; i < DEPTH; i++) peek(i, "R6_kept");
        // R7 the select changes the word in the same cycle, idle holds
        for (int i = DEPTH - 1; i >= 0; i--) peek(i, "R7_idle");
        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit r, c, rd;
            int idx;
            string tg;
            r   = ($urandom % 64) != 0;
            c   = ($urandom % 3) == 0;
            rd  = ($urandom % 3) == 0;
            idx = int'($urandom % DEPTH);
            tg  = !r ? "R6_rand" : (c && rd) ? "R5_rand" : c ? "R1_rand" : rd ? "R4_rand" : "R7_rand";
            step(r, c, 28'($urandom), rd, idx, tg);
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule